// File: doc/BRIEF.md
# Transactional Pause Stack

This block is a per-warp control stack for transactional execution on a SIMT core. When a warp enters a transaction, the block records a retry slot and a running group. At a transactional load or store, a conflict filter reports which lanes touch addresses that committing transactions already hold. Those lanes are parked in their own stack entry, which also records the transactional log pointer. The remaining lanes carry on.

After each commit attempt, the lanes that failed validation are merged into the retry slot, and the running group is popped. A parked group then becomes active, and the log walker is told to rewind its pointer to the value the group saved. When only the retry slot remains, its lanes are re-issued from the transaction start as a new group, or the warp leaves the transaction if no lane failed.

Only one transaction per warp is held. A begin that arrives while a transaction is open is ignored. The stack depth must be a power of two, no smaller than 2.

Top module: `txn_pause_stack`

## Requirements
- R1: After reset the block is idle: `txn_busy_o`=0, `active_mask_o`=0, `pc_o`=0, `restore_valid_o`=0, `overflow_o`=0.
- R2: A begin with a nonzero mask while idle makes, from the next cycle, `txn_busy_o`=1, `active_mask_o` equal to that mask and `pc_o` equal to `begin_pc_i`. A begin while busy, or one with an all-zero mask, changes no output.
- R3: A load/store whose conflict mask covers some but not all active lanes makes, next cycle, `active_mask_o` = active & ~conflict and `pc_o` = `ldst_pc_i`. The conflicting lanes are parked together with the `log_ptr_i` value of that cycle.
- R4: A load/store whose conflict mask covers none or all of the active lanes pauses nothing: `active_mask_o` and `pc_o` stay unchanged.
- R5: A commit that pops a running group with a parked group below it makes, next cycle, `active_mask_o` equal to the parked lanes and `pc_o` equal to their saved PC. In that same cycle `restore_valid_o` pulses for one cycle, with `restore_ptr_o` equal to the saved log pointer.
- R6: Lanes set in `fail_i` at a commit accumulate in the retry slot. When the retry slot is the only entry left and is nonempty, the next cycle shows `active_mask_o` = the accumulated lanes and `pc_o` = the begin PC. In that cycle `restore_valid_o` pulses with `restore_ptr_o` equal to the log pointer captured at begin, and the retry slot is cleared.
- R7: When the retry slot is reached with no failed lanes, the warp leaves the transaction: next cycle `txn_busy_o`=0 and `active_mask_o`=0, with no restore pulse.
- R8: A pause that needs a push onto a full stack of DEPTH entries sets `overflow_o`, which stays set until reset. The pause is dropped, so `active_mask_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_i | input | 1 | Transaction begin |
| begin_mask_i | input | NT | Lanes entering the transaction |
| begin_pc_i | input | PCW | Transaction start PC |
| ldst_i | input | 1 | Transactional load/store checked against the conflict filter |
| ldst_pc_i | input | PCW | PC of that load/store |
| conflict_i | input | NT | Lanes whose address hit the conflict filter |
| commit_i | input | 1 | Commit attempt of the running group finished |
| fail_i | input | NT | Lanes that failed validation |
| log_ptr_i | input | LPW | Current transactional log pointer |
| active_mask_o | output | NT | Lanes executing now |
| pc_o | output | PCW | PC of the top entry |
| txn_busy_o | output | 1 | Transaction open |
| restore_valid_o | output | 1 | One-cycle pulse: rewind the log pointer |
| restore_ptr_o | output | LPW | Log pointer value to rewind to |
| overflow_o | output | 1 | Sticky flag: a push hit a full stack |

## Verification
Every command is taken at one clock edge, and all its results appear together at the next edge. The new mask and PC come from the registered stack top, and the restore pulse and pointer are registered outputs. The bench drives each command at a falling edge and checks every output 2 ns after the rising edge that takes it. It clears the command before the next edge, so it also checks that the restore pulse lasts only one cycle. A near-exhaustive sweep crosses every begin mask with every conflict mask and every first-commit failure mask on a 4-lane, depth-4 configuration. The expected masks, PCs and log pointers are derived from set arithmetic in the bench.

// File: rtl/txn_pause_stack.sv
module txn_pause_stack #(
  parameter int NT    = 8,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  parameter int LPW   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           begin_i,
  input  logic [NT-1:0]  begin_mask_i,
  input  logic [PCW-1:0] begin_pc_i,
  input  logic           ldst_i,
  input  logic [PCW-1:0] ldst_pc_i,
  input  logic [NT-1:0]  conflict_i,
  input  logic           commit_i,
  input  logic [NT-1:0]  fail_i,
  input  logic [LPW-1:0] log_ptr_i,
  output logic [NT-1:0]  active_mask_o,
  output logic [PCW-1:0] pc_o,
  output logic           txn_busy_o,
  output logic           restore_valid_o,
  output logic [LPW-1:0] restore_ptr_o,
  output logic           overflow_o
);
  localparam int IW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [NT-1:0]  mask_q [DEPTH];
  logic [PCW-1:0] pc_q   [DEPTH];
  logic [LPW-1:0] log_q  [DEPTH];
  logic [SPW-1:0] sp_q;

  wire [IW-1:0] top   = IW'(sp_q - SPW'(1));
  wire [IW-1:0] below = IW'(sp_q - SPW'(2));
  wire [IW-1:0] nxt   = IW'(sp_q);
  wire busy     = sp_q != '0;
  wire in_trans = sp_q >= SPW'(2);
  wire full     = sp_q == SPW'(DEPTH);

  wire [NT-1:0] top_mask  = mask_q[top];
  wire [NT-1:0] paused    = conflict_i & top_mask;
  wire [NT-1:0] running   = top_mask & ~conflict_i;
  wire [NT-1:0] retry_new = mask_q[0] | (fail_i & top_mask);

  wire do_begin  = begin_i && !busy && (begin_mask_i != '0);
  wire do_commit = !do_begin && commit_i && in_trans;
  wire do_pause  = !do_begin && !commit_i && ldst_i && in_trans &&
                   (paused != '0) && (running != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q            <= '0;
      overflow_o      <= 1'b0;
      restore_valid_o <= 1'b0;
      restore_ptr_o   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mask_q[i] <= '0;
        pc_q[i]   <= '0;
        log_q[i]  <= '0;
      end
    end else begin
      restore_valid_o <= 1'b0;
      if (do_begin) begin
        mask_q[0] <= '0;
        pc_q[0]   <= begin_pc_i;
        log_q[0]  <= log_ptr_i;
        mask_q[1] <= begin_mask_i;
        pc_q[1]   <= begin_pc_i;
        log_q[1]  <= log_ptr_i;
        sp_q      <= SPW'(2);
      end else if (do_commit) begin
        if (sp_q > SPW'(2)) begin
          mask_q[0]       <= retry_new;
          sp_q            <= sp_q - SPW'(1);
          restore_valid_o <= 1'b1;
          restore_ptr_o   <= log_q[below];
        end else if (retry_new != '0) begin
          mask_q[1]       <= retry_new;
          pc_q[1]         <= pc_q[0];
          log_q[1]        <= log_q[0];
          mask_q[0]       <= '0;
          restore_valid_o <= 1'b1;
          restore_ptr_o   <= log_q[0];
        end else begin
          mask_q[0] <= '0;
          sp_q      <= '0;
        end
      end else if (do_pause) begin
        if (full) begin
          overflow_o <= 1'b1;
        end else begin
          mask_q[top] <= paused;
          pc_q[top]   <= ldst_pc_i;
          log_q[top]  <= log_ptr_i;
          mask_q[nxt] <= running;
          pc_q[nxt]   <= ldst_pc_i;
          log_q[nxt]  <= log_ptr_i;
          sp_q        <= sp_q + SPW'(1);
        end
      end
    end
  end

  assign txn_busy_o    = busy;
  assign active_mask_o = in_trans ? top_mask : '0;
  assign pc_o          = busy ? pc_q[top] : '0;

  assert_busy_has_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_busy_o |-> (active_mask_o != '0));
  assert_begin_loads_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !txn_busy_o && begin_mask_i != '0) |=> (active_mask_o == $past(begin_mask_i)));
  assert_pause_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ldst_i && !commit_i && !begin_i && txn_busy_o) |=>
      ((active_mask_o & ~$past(active_mask_o)) == '0));
  assert_restore_after_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid_o |-> $past(commit_i));
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(ldst_i));
endmodule

// File: tb/txn_pause_stack_tb.sv
`timescale 1ns/1ps
module txn_pause_stack_tb_top;
  localparam int NT = 4, DEPTH = 4, PCW = 16, LPW = 12;
  localparam logic [PCW-1:0] BPC = 16'h0100, LPC = 16'h0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic begin_i = 0, ldst_i = 0, commit_i = 0;
  logic [NT-1:0] begin_mask_i = '0, conflict_i = '0, fail_i = '0;
  logic [PCW-1:0] begin_pc_i = '0, ldst_pc_i = '0;
  logic [LPW-1:0] log_ptr_i = '0;
  logic [NT-1:0] active_mask_o;
  logic [PCW-1:0] pc_o;
  logic txn_busy_o, restore_valid_o, overflow_o;
  logic [LPW-1:0] restore_ptr_o;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  txn_pause_stack #(.NT(NT), .DEPTH(DEPTH), .PCW(PCW), .LPW(LPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .begin_mask_i(begin_mask_i),
    .begin_pc_i(begin_pc_i), .ldst_i(ldst_i), .ldst_pc_i(ldst_pc_i),
    .conflict_i(conflict_i), .commit_i(commit_i), .fail_i(fail_i),
    .log_ptr_i(log_ptr_i), .active_mask_o(active_mask_o), .pc_o(pc_o),
    .txn_busy_o(txn_busy_o), .restore_valid_o(restore_valid_o),
    .restore_ptr_o(restore_ptr_o), .overflow_o(overflow_o));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic outs(string req, logic b, logic [NT-1:0] m, logic [PCW-1:0] p,
                      logic rv, logic [LPW-1:0] rp);
    chk({req, " busy"}, 32'(txn_busy_o), 32'(b));
    chk({req, " mask"}, 32'(active_mask_o), 32'(m));
    chk({req, " pc"}, 32'(pc_o), 32'(p));
    chk({req, " rvalid"}, 32'(restore_valid_o), 32'(rv));
    if (rv) chk({req, " rptr"}, 32'(restore_ptr_o), 32'(rp));
  endtask

  task automatic fin();
    @(posedge clk); #2;
    begin_i = 0; ldst_i = 0; commit_i = 0;
  endtask
  task automatic do_begin(logic [NT-1:0] m, logic [LPW-1:0] lp);
    @(negedge clk); begin_i = 1; begin_mask_i = m; begin_pc_i = BPC; log_ptr_i = lp; fin();
  endtask
  task automatic do_ldst(logic [NT-1:0] c, logic [LPW-1:0] lp);
    @(negedge clk); ldst_i = 1; conflict_i = c; ldst_pc_i = LPC; log_ptr_i = lp; fin();
  endtask
  task automatic do_commit(logic [NT-1:0] f);
    @(negedge clk); commit_i = 1; fail_i = f; fin();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    outs("R1", 0, 0, 0, 0, 0);
    chk("R1 overflow", 32'(overflow_o), 0);

    do_begin(4'b0000, 12'h001);
    outs("R2 zero-mask begin", 0, 0, 0, 0, 0);

    for (int m = 1; m < 16; m++) begin
      for (int c = 0; c < 16; c++) begin
        for (int f = 0; f < 16; f++) begin
          logic [NT-1:0] mm, cc, ff, run, par, rty;
          logic [LPW-1:0] l0, l1;
          mm = NT'(m); cc = NT'(c); ff = NT'(f);
          l0 = 12'h100 + 12'(m); l1 = 12'h200 + 12'(c);
          run = mm & ~cc; par = mm & cc;
          do_begin(mm, l0);
          outs("R2", 1, mm, BPC, 0, 0);
          do_ldst(cc, l1);
          if (par != 0 && run != 0) begin
            outs("R3", 1, run, LPC, 0, 0);
            do_commit(ff);
            rty = ff & run;
            outs("R5", 1, par, LPC, 1, l1);
            do_commit(~ff);
            rty = rty | (~ff & par);
          end else begin
            outs("R4", 1, mm, BPC, 0, 0);
            do_commit(ff);
            rty = ff & mm;
          end
          if (rty != 0) begin
            outs("R6", 1, rty, BPC, 1, l0);
            do_begin(4'b1111, 12'h3ff);
            outs("R2 begin while busy", 1, rty, BPC, 0, 0);
            do_commit(0);
          end
          outs("R7", 0, 0, 0, 0, 0);
        end
      end
    end

    chk("R8 no overflow yet", 32'(overflow_o), 0);
    do_ldst(4'b0001, 12'h010);
    outs("R7 idle ldst", 0, 0, 0, 0, 0);
    do_begin(4'b1111, 12'h020);
    do_ldst(4'b0001, 12'h021);
    outs("R3 first pause", 1, 4'b1110, LPC, 0, 0);
    do_ldst(4'b0010, 12'h022);
    outs("R3 second pause", 1, 4'b1100, LPC, 0, 0);
    chk("R8 full not overflow", 32'(overflow_o), 0);
    do_ldst(4'b0100, 12'h023);
    outs("R8 dropped pause", 1, 4'b1100, LPC, 0, 0);
    chk("R8 overflow set", 32'(overflow_o), 1);
    do_commit(4'b1000);
    outs("R5 unwind 1", 1, 4'b0010, LPC, 1, 12'h022);
    chk("R8 overflow sticky", 32'(overflow_o), 1);
    do_commit(0);
    outs("R5 unwind 2", 1, 4'b0001, LPC, 1, 12'h021);
    do_commit(4'b0001);
    outs("R6 accumulated", 1, 4'b1001, BPC, 1, 12'h020);
    do_commit(0);
    outs("R7 exit", 0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule